// File: doc/BRIEF.md
# Lagged Reply Sequencer for a Chained Sensor Slave

This block sits inside a slave node on a daisy-chained sensor bus. It decides what the slave sends back during each frame slot. A frame receiver delivers one strobe per received command. With the strobe come four inputs: the result of the integrity (CRC) check, whether the address matched this slave, the size of the command, and the data word the slave owes for that command. Replies run one frame behind commands. The reply to command N goes out in the slot of command N+1.

When a frame fails its integrity check, the slave stays silent for that slot. The owed reply is kept, not replaced. The next good command, of any content but of the wanted size, collects the reply that was still pending from before the error. Frames that pass the check but carry another slave's address are ignored. A saturating counter records how many frames were rejected.

Top module: `lagreply_seq`

## Requirements
- R1: After reset `tx_en` is 0, `err_count` is 0 and no reply is pending, so the first accepted frame produces no `tx_en` pulse.
- R2: An accepted frame (`crc_ok`=1, `addr_hit`=1 at `frame_stb`) that finds a reply pending raises `tx_en` in the cycle after the strobe. `tx_word` then holds the `reply_data` of the previously accepted frame, and the frame's own `reply_data` becomes the new pending reply.
- R3: A frame with `crc_ok`=0 never raises `tx_en` in the cycle after its strobe, whatever `addr_hit` is.
- R4: A frame with `crc_ok`=0 leaves the pending reply unchanged. The next accepted frame delivers the reply owed from before the error.
- R5: A frame with `crc_ok`=1 and `addr_hit`=0 raises no `tx_en`, leaves the pending reply unchanged and leaves `err_count` unchanged.
- R6: `tx_long` equals `cmd_long` of the frame that carries the reply. When `cmd_long`=1, `tx_word` is the full pending word. When `cmd_long`=0, `tx_word` holds only the low SHORT_W bits of the pending word, and its upper bits are 0.
- R7: `err_count` increases by one for each frame with `crc_ok`=0 and stays at 2**CNT_W-1 once there (255 with the default width).
- R8: `tx_en` is high for exactly one cycle per delivery and is never raised twice for the same pending reply.
- R9: Between deliveries, `tx_word` and `tx_long` keep the values of the last delivery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse: a received frame is presented |
| crc_ok | input | 1 | Frame passed its integrity check |
| addr_hit | input | 1 | Frame is addressed to this slave |
| cmd_long | input | 1 | Command size: 1 long, 0 short |
| reply_data | input | DATA_W | Data owed in reply to this command |
| tx_en | output | 1 | Pulse: send a reply in this slot |
| tx_word | output | DATA_W | Reply word being sent |
| tx_long | output | 1 | Reply size, taken from the carrying command |
| err_count | output | CNT_W | Saturating count of rejected frames |

## Verification
The bench builds the block with DATA_W=16, SHORT_W=8 and CNT_W=4. The narrow counter makes the saturation ceiling of 15 reachable within a short burst of corrupted frames. The split word width makes the short-reply masking visible. A scoreboard predicts every delivery from the frame history. Fixed scenarios cover the reset gap, recovery after an error, foreign-address frames and both sizes. A pseudo-random stream then mixes rejected, foreign and accepted frames.

// File: rtl/lagreply_pkg.sv
package lagreply_pkg;
   typedef enum logic [1:0] {
      FK_IDLE    = 2'd0,
      FK_TAKE    = 2'd1,
      FK_CORRUPT = 2'd2,
      FK_FOREIGN = 2'd3
   } frame_kind_e;
endpackage

// File: rtl/lagreply_classify.sv
module lagreply_classify
   import lagreply_pkg::*;
(
   input  logic        stb,
   input  logic        crc_ok,
   input  logic        addr_hit,
   output frame_kind_e kind
);
   always_comb begin
      if (!stb)         kind = FK_IDLE;
      else if (!crc_ok) kind = FK_CORRUPT;
      else if (!addr_hit) kind = FK_FOREIGN;
      else              kind = FK_TAKE;
   end
endmodule

// File: rtl/lagreply_pending.sv
module lagreply_pending #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              hold_req,
   input  logic [DATA_W-1:0] new_word,
   output logic [DATA_W-1:0] pend_word,
   output logic              pend_vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_word <= '0;
         pend_vld  <= 1'b0;
      end else if (take) begin
         pend_word <= new_word;
         pend_vld  <= 1'b1;
      end
   end

   AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      hold_req |=> ($stable(pend_word) && $stable(pend_vld))); // R4
endmodule

// File: rtl/lagreply_errcnt.sv
module lagreply_errcnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        count <= '0;
      else if (bump && count != CNT_TOP) count <= count + 1'b1;
   end

   AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_TOP) |=> (count == CNT_TOP)); // R7
   AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bump |=> $stable(count)); // R5
endmodule

// File: rtl/lagreply_seq.sv
module lagreply_seq
   import lagreply_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SHORT_W = 8,
   parameter int CNT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              crc_ok,
   input  logic              addr_hit,
   input  logic              cmd_long,
   input  logic [DATA_W-1:0] reply_data,
   output logic              tx_en,
   output logic [DATA_W-1:0] tx_word,
   output logic              tx_long,
   output logic [CNT_W-1:0]  err_count
);
   localparam int PAD_W = DATA_W - SHORT_W;

   if (DATA_W < 1) begin : g_bad_data
      $error("lagreply_seq: DATA_W must be positive");
   end
   if (SHORT_W < 1 || SHORT_W > DATA_W) begin : g_bad_short
      $error("lagreply_seq: SHORT_W must lie in 1..DATA_W");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("lagreply_seq: CNT_W must lie in 1..32");
   end

   frame_kind_e       kind;
   logic              take;
   logic              corrupt;
   logic [DATA_W-1:0] pend_word;
   logic              pend_vld;
   logic [DATA_W-1:0] shaped;

   lagreply_classify u_class (
      .stb      (frame_stb),
      .crc_ok   (crc_ok),
      .addr_hit (addr_hit),
      .kind     (kind)
   );

   assign take    = (kind == FK_TAKE);
   assign corrupt = (kind == FK_CORRUPT);

   lagreply_pending #(.DATA_W(DATA_W)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .hold_req  (corrupt || kind == FK_FOREIGN),
      .new_word  (reply_data),
      .pend_word (pend_word),
      .pend_vld  (pend_vld)
   );

   lagreply_errcnt #(.CNT_W(CNT_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (corrupt),
      .count (err_count)
   );

   if (PAD_W == 0) begin : g_same_width
      assign shaped = pend_word;
   end else begin : g_masked
      assign shaped = cmd_long ? pend_word
                               : {{PAD_W{1'b0}}, pend_word[SHORT_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en   <= 1'b0;
         tx_word <= '0;
         tx_long <= 1'b0;
      end else begin
         tx_en <= take && pend_vld;
         if (take && pend_vld) begin
            tx_word <= shaped;
            tx_long <= cmd_long;
         end
      end
   end

   AST_CORRUPT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !crc_ok) |=> !tx_en); // R3
   AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && crc_ok && !addr_hit) |=> !tx_en); // R5
   AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !pend_vld) |=> !tx_en); // R1
   AST_SIZE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pend_vld) |=> (tx_en && tx_long == $past(cmd_long))); // R6
   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !take) |=> !tx_en); // R8
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && pend_vld) |=> ($stable(tx_word) && $stable(tx_long))); // R9
endmodule

// File: tb/tb_lagreply_seq.sv
module tb_lagreply_seq;
   localparam int DW = 16;
   localparam int SW = 8;
   localparam int CW = 4;
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic          crc_ok = 1'b0;
   logic          addr_hit = 1'b0;
   logic          cmd_long = 1'b0;
   logic [DW-1:0] reply_data = '0;
   logic          tx_en;
   logic [DW-1:0] tx_word;
   logic          tx_long;
   logic [CW-1:0] err_count;

   always #5 clk = ~clk;

   lagreply_seq #(.DATA_W(DW), .SHORT_W(SW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .crc_ok(crc_ok),
      .addr_hit(addr_hit), .cmd_long(cmd_long), .reply_data(reply_data),
      .tx_en(tx_en), .tx_word(tx_word), .tx_long(tx_long), .err_count(err_count)
   );

   int total = 0;
   int bad = 0;
   logic [DW:0] sb_q[$];
   logic [DW-1:0] m_word = '0;
   logic          m_vld = 1'b0;
   logic [CW-1:0] m_err = '0;
   logic [DW-1:0] last_word = '0;
   logic          last_long = 1'b0;
   bit            finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pop expected deliveries as tx_en pulses
   always @(negedge clk) begin
      if (rst_n && tx_en) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R8 unexpected tx_en", 32'(tx_word), 32'hFFFF_FFFF);
         end else begin
            logic [DW:0] e;
            e = sb_q.pop_front();
            chk(tx_word == e[DW-1:0], "R2/R6 tx_word", 32'(tx_word), 32'(e[DW-1:0]));
            chk(tx_long == e[DW], "R6 tx_long", 32'(tx_long), 32'(e[DW]));
            last_word = e[DW-1:0];
            last_long = e[DW];
         end
      end
   end

   task automatic send(input logic c, input logic h, input logic l,
                       input logic [DW-1:0] d, input string req);
      logic exp_en;
      exp_en = 1'b0;
      @(negedge clk);
      frame_stb = 1'b1; crc_ok = c; addr_hit = h; cmd_long = l; reply_data = d;
      if (!c) begin
         if (m_err != TOP) m_err = m_err + 1'b1;
      end else if (h) begin
         if (m_vld) begin
            exp_en = 1'b1;
            sb_q.push_back({l, l ? m_word : {{(DW-SW){1'b0}}, m_word[SW-1:0]}});
         end
         m_word = d;
         m_vld  = 1'b1;
      end
      @(negedge clk);
      frame_stb = 1'b0;
      chk(tx_en == exp_en, req, 32'(tx_en), 32'(exp_en));
      chk(err_count == m_err, "R7 err_count", 32'(err_count), 32'(m_err));
   endtask

   initial begin
      #200000;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      chk(tx_en == 1'b0, "R1 reset tx_en", 32'(tx_en), 0);
      chk(err_count == '0, "R1 reset err_count", 32'(err_count), 0);
      rst_n = 1'b1;
      send(1, 1, 1, 16'hA1A1, "R1 first frame silent");
      send(1, 1, 1, 16'hB2B2, "R2 lagged reply");
      send(1, 1, 0, 16'hC3C3, "R6 short reply");
      send(0, 1, 1, 16'hDEAD, "R3 corrupt silent");
      send(0, 0, 1, 16'hBEEF, "R3 corrupt foreign silent");
      send(1, 1, 1, 16'hD4D4, "R4 owed reply after error");
      send(1, 0, 0, 16'h5555, "R5 foreign ignored");
      send(1, 1, 0, 16'hE5E5, "R5 pending kept after foreign");
      repeat (4) @(negedge clk);
      chk(tx_en == 1'b0, "R8 no repeat pulse", 32'(tx_en), 0);
      chk(tx_word == last_word, "R9 tx_word hold", 32'(tx_word), 32'(last_word));
      chk(tx_long == last_long, "R9 tx_long hold", 32'(tx_long), 32'(last_long));
      for (int i = 0; i < 20; i++) send(0, 1, 1, 16'(i), "R7 corrupt burst");
      chk(err_count == TOP, "R7 saturated", 32'(err_count), 32'(TOP));
      send(1, 1, 1, 16'hF6F6, "R4 owed after burst");
      lfsr = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], lfsr[4], lfsr ^ 16'h3C5A,
              "R2 mixed stream");
      end
      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R8 all deliveries seen", 32'(sb_q.size()), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule